// File: doc/BRIEF.md
# ALU Control and Immediate Extender

This combinational unit sits in the decode stage of a 32-bit integer pipeline. It takes the raw instruction word and produces two values. The first is the 32-bit immediate operand for the ALU's second input. The second is the operation code that the ALU will carry out.

A 2-bit extension select picks how the immediate is formed from the low instruction bits:

- sign-extended 16-bit, used by loads, stores, conditional branches and signed-immediate arithmetic;
- zero-extended 16-bit, used by unsigned-immediate arithmetic;
- sign-extended 26-bit, used by PC-relative jumps;
- high-half, which loads a constant into the upper 16 bits.

A 2-bit operation-source select picks where the ALU operation comes from:

- the function field of register-register instructions;
- the opcode of immediate instructions;
- a forced add, used for address arithmetic;
- a zero test, used for conditional branches.

When the zero test is selected, the unit also reports whether operand A is zero.

The unit holds no state. Every output follows its inputs within the same cycle.

Top module: `alu_ctl_imm_ext`

## Requirements
- R1: With the extension select at 0, the immediate is instruction bits 15:0 with bit 15 copied into bits 31:16.
- R2: With the extension select at 1, the immediate is instruction bits 15:0 with bits 31:16 zero.
- R3: With the extension select at 2, the immediate is instruction bits 25:0 with bit 25 copied into bits 31:26.
- R4: With the extension select at 3, the immediate carries instruction bits 15:0 in bits 31:16 and zeros in bits 15:0.
- R5: With the op select at 0, the ALU op is decoded from instruction bits 5:0 as follows. The encodings 0x20 and 0x21 give ADD (0). 0x22 and 0x23 give SUB (1). 0x24 gives AND (2), 0x25 gives OR (3) and 0x26 gives XOR (4). 0x04 gives SLL (5), 0x06 gives SRL (6) and 0x07 gives SRA (7). 0x2A gives SLT (8) and 0x2B gives SLTU (9).
- R6: With the op select at 1, the ALU op is decoded from instruction bits 31:26 as follows. 0x08 and 0x09 give ADD (0). 0x0A and 0x0B give SUB (1). 0x0C gives AND (2), 0x0D gives OR (3) and 0x0E gives XOR (4). 0x0F gives PASSB (10). 0x14 gives SLL (5), 0x16 gives SRL (6) and 0x17 gives SRA (7). 0x1A gives SLT (8) and 0x1B gives SLTU (9).
- R7: With the op select at 2, the ALU op is ADD (0) whatever the instruction holds.
- R8: With the op select at 3, the ALU op is ZTEST (11), and the zero flag is 1 exactly when operand A is zero. With any other op select, the zero flag is 0.
- R9: A function or opcode value not listed in R5 or R6 yields ADD (0).
- R10: Instruction bits outside the field chosen by each select have no effect on the outputs. All outputs change in the same cycle as the inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 32 | Instruction word |
| ext_sel | input | 2 | Immediate form: 0 sext16, 1 zext16, 2 sext26, 3 high16 |
| op_sel | input | 2 | ALU op source: 0 function, 1 opcode, 2 add, 3 zero test |
| opa | input | 32 | Operand A, examined by the zero test |
| imm | output | 32 | Extended immediate |
| alu_op | output | 4 | ALU operation code |
| zero_hit | output | 1 | Zero-test result |

## Verification
The extender is driven with immediates whose top bit is set and then clear. This separates the sign-extending forms from the zero-extending one. The same low bits are then checked under the high-half form, which catches swapped halves. The decoders are swept over every listed function and opcode value, then over unlisted values and with the forced-add and zero-test selects holding conflicting fields. This shows each select really chooses its source. Operand A is driven to zero, to one and to only the top bit set, to confirm the zero flag tests the whole word. Bits outside the selected field are then flipped to show that they are ignored.

// File: rtl/alu_ctl_imm_ext.sv
module alu_ctl_imm_ext (
  input  logic [31:0] instr,
  input  logic [1:0]  ext_sel,
  input  logic [1:0]  op_sel,
  input  logic [31:0] opa,
  output logic [31:0] imm,
  output logic [3:0]  alu_op,
  output logic        zero_hit
);
  localparam logic [3:0] OP_ADD  = 4'd0;
  localparam logic [3:0] OP_SUB  = 4'd1;
  localparam logic [3:0] OP_AND  = 4'd2;
  localparam logic [3:0] OP_OR   = 4'd3;
  localparam logic [3:0] OP_XOR  = 4'd4;
  localparam logic [3:0] OP_SLL  = 4'd5;
  localparam logic [3:0] OP_SRL  = 4'd6;
  localparam logic [3:0] OP_SRA  = 4'd7;
  localparam logic [3:0] OP_SLT  = 4'd8;
  localparam logic [3:0] OP_SLTU = 4'd9;
  localparam logic [3:0] OP_PASB = 4'd10;
  localparam logic [3:0] OP_ZTST = 4'd11;

  logic [3:0] func_op, opc_op;
  wire  [15:0] lo16 = instr[15:0];
  wire  [25:0] lo26 = instr[25:0];

  always_comb begin
    unique case (ext_sel)
      2'd0: imm = {{16{lo16[15]}}, lo16};
      2'd1: imm = {16'h0000, lo16};
      2'd2: imm = {{6{lo26[25]}}, lo26};
      default: imm = {lo16, 16'h0000};
    endcase
  end

  always_comb begin
    case (instr[5:0])
      6'h22, 6'h23: func_op = OP_SUB;
      6'h24:        func_op = OP_AND;
      6'h25:        func_op = OP_OR;
      6'h26:        func_op = OP_XOR;
      6'h04:        func_op = OP_SLL;
      6'h06:        func_op = OP_SRL;
      6'h07:        func_op = OP_SRA;
      6'h2A:        func_op = OP_SLT;
      6'h2B:        func_op = OP_SLTU;
      default:      func_op = OP_ADD;
    endcase
  end

  always_comb begin
    case (instr[31:26])
      6'h0A, 6'h0B: opc_op = OP_SUB;
      6'h0C:        opc_op = OP_AND;
      6'h0D:        opc_op = OP_OR;
      6'h0E:        opc_op = OP_XOR;
      6'h0F:        opc_op = OP_PASB;
      6'h14:        opc_op = OP_SLL;
      6'h16:        opc_op = OP_SRL;
      6'h17:        opc_op = OP_SRA;
      6'h1A:        opc_op = OP_SLT;
      6'h1B:        opc_op = OP_SLTU;
      default:      opc_op = OP_ADD;
    endcase
  end

  always_comb begin
    unique case (op_sel)
      2'd0: alu_op = func_op;
      2'd1: alu_op = opc_op;
      2'd2: alu_op = OP_ADD;
      default: alu_op = OP_ZTST;
    endcase
  end

  assign zero_hit = (op_sel == 2'd3) && (opa == 32'd0);
endmodule

module alu_ctl_imm_ext_chk (
  input logic [31:0] instr,
  input logic [1:0]  ext_sel,
  input logic [1:0]  op_sel,
  input logic [31:0] opa,
  input logic [31:0] imm,
  input logic [3:0]  alu_op,
  input logic        zero_hit
);
  always_comb begin
    if (ext_sel == 2'd0)
      assert_sext16_R1: assert (imm[15:0] == instr[15:0] && (imm[31:16] == 16'h0 || imm[31:16] == 16'hFFFF) && imm[31] == instr[15]);
    if (ext_sel == 2'd1)
      assert_zext16_R2: assert (imm[31:16] == 16'h0 && imm[15:0] == instr[15:0]);
    if (ext_sel == 2'd2)
      assert_sext26_R3: assert (imm[25:0] == instr[25:0] && imm[31] == instr[25]);
    if (ext_sel == 2'd3)
      assert_high16_R4: assert (imm[15:0] == 16'h0 && imm[31:16] == instr[15:0]);
    if (op_sel == 2'd2)
      assert_forced_add_R7: assert (alu_op == 4'd0);
    if (op_sel == 2'd3)
      assert_ztest_op_R8: assert (alu_op == 4'd11 && zero_hit == (opa == 32'd0));
    else
      assert_zero_idle_R8: assert (!zero_hit);
    if (op_sel != 2'd3)
      assert_no_ztest_R5: assert (alu_op != 4'd11);
  end
endmodule

bind alu_ctl_imm_ext alu_ctl_imm_ext_chk u_chk (
  .instr(instr), .ext_sel(ext_sel), .op_sel(op_sel), .opa(opa),
  .imm(imm), .alu_op(alu_op), .zero_hit(zero_hit)
);

// File: tb/alu_ctl_imm_ext_bench.sv
`timescale 1ns/1ps
module alu_ctl_imm_ext_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [31:0] instr = '0;
  logic [1:0]  ext_sel = '0;
  logic [1:0]  op_sel = '0;
  logic [31:0] opa = '0;
  logic [31:0] imm;
  logic [3:0]  alu_op;
  logic        zero_hit;

  int total = 0;
  int bad = 0;

  alu_ctl_imm_ext u_alu_ctl_imm_ext (
    .instr(instr), .ext_sel(ext_sel), .op_sel(op_sel), .opa(opa),
    .imm(imm), .alu_op(alu_op), .zero_hit(zero_hit)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic apply(input logic [31:0] i, input logic [1:0] es, input logic [1:0] os, input logic [31:0] a);
    @(negedge clk);
    instr = i; ext_sel = es; op_sel = os; opa = a;
    #1;
  endtask

  task automatic t_idle;
    apply(32'h0, 2'd0, 2'd0, 32'h0);
    chk("R10 idle imm", imm, 32'h0);
    chk("R9 idle op", {28'h0, alu_op}, 32'd0);
    chk("R8 idle zero", {31'h0, zero_hit}, 32'd0);
  endtask

  task automatic t_ext;
    apply(32'h0000_8001, 2'd0, 2'd2, 32'h1);
    chk("R1 neg", imm, 32'hFFFF_8001);
    apply(32'h0000_7FFF, 2'd0, 2'd2, 32'h1);
    chk("R1 pos", imm, 32'h0000_7FFF);
    apply(32'h0000_8001, 2'd1, 2'd2, 32'h1);
    chk("R2 msb", imm, 32'h0000_8001);
    apply(32'h0200_0004, 2'd2, 2'd2, 32'h1);
    chk("R3 neg", imm, 32'hFE00_0004);
    apply(32'h01FF_FFFF, 2'd2, 2'd2, 32'h1);
    chk("R3 pos", imm, 32'h01FF_FFFF);
    apply(32'h0000_ABCD, 2'd3, 2'd2, 32'h1);
    chk("R4 high", imm, 32'hABCD_0000);
  endtask

  task automatic t_func;
    logic [5:0] codes [12] = '{6'h20,6'h21,6'h22,6'h23,6'h24,6'h25,6'h26,6'h04,6'h06,6'h07,6'h2A,6'h2B};
    logic [3:0] ops   [12] = '{4'd0,4'd0,4'd1,4'd1,4'd2,4'd3,4'd4,4'd5,4'd6,4'd7,4'd8,4'd9};
    for (int k = 0; k < 12; k++) begin
      apply({6'h0F, 20'h0, codes[k]}, 2'd0, 2'd0, 32'h0);
      chk("R5 func", {28'h0, alu_op}, {28'h0, ops[k]});
    end
  endtask

  task automatic t_opc;
    logic [5:0] codes [13] = '{6'h08,6'h09,6'h0A,6'h0B,6'h0C,6'h0D,6'h0E,6'h0F,6'h14,6'h16,6'h17,6'h1A,6'h1B};
    logic [3:0] ops   [13] = '{4'd0,4'd0,4'd1,4'd1,4'd2,4'd3,4'd4,4'd10,4'd5,4'd6,4'd7,4'd8,4'd9};
    for (int k = 0; k < 13; k++) begin
      apply({codes[k], 20'h0, 6'h22}, 2'd0, 2'd1, 32'h0);
      chk("R6 opcode", {28'h0, alu_op}, {28'h0, ops[k]});
    end
  endtask

  task automatic t_unknown;
    apply({6'h3F, 20'h0, 6'h3F}, 2'd0, 2'd0, 32'h0);
    chk("R9 func unknown", {28'h0, alu_op}, 32'd0);
    apply({6'h3F, 20'h0, 6'h3F}, 2'd0, 2'd1, 32'h0);
    chk("R9 opcode unknown", {28'h0, alu_op}, 32'd0);
  endtask

  task automatic t_forced;
    apply({6'h0A, 20'h0, 6'h22}, 2'd0, 2'd2, 32'h0);
    chk("R7 forced add", {28'h0, alu_op}, 32'd0);
    chk("R7 no zero flag", {31'h0, zero_hit}, 32'd0);
  endtask

  task automatic t_zero;
    apply({6'h0A, 20'h0, 6'h22}, 2'd0, 2'd3, 32'h0);
    chk("R8 ztest op", {28'h0, alu_op}, 32'd11);
    chk("R8 zero hit", {31'h0, zero_hit}, 32'd1);
    apply(32'h0, 2'd0, 2'd3, 32'h1);
    chk("R8 one", {31'h0, zero_hit}, 32'd0);
    apply(32'h0, 2'd0, 2'd3, 32'h8000_0000);
    chk("R8 msb", {31'h0, zero_hit}, 32'd0);
    apply(32'h0, 2'd0, 2'd1, 32'h0);
    chk("R8 other sel", {31'h0, zero_hit}, 32'd0);
  endtask

  task automatic t_ignore;
    apply(32'hFFFF_1234, 2'd0, 2'd0, 32'h0);
    chk("R10 upper ignored sext16", imm, 32'h0000_1234);
    apply(32'hFFFF_1234, 2'd1, 2'd0, 32'h0);
    chk("R10 upper ignored zext16", imm, 32'h0000_1234);
    apply(32'hFFFF_1234, 2'd3, 2'd0, 32'h0);
    chk("R10 upper ignored high16", imm, 32'h1234_0000);
    apply(32'hFC00_0010, 2'd2, 2'd0, 32'h0);
    chk("R10 top ignored sext26", imm, 32'h0000_0010);
    apply({6'h0C, 20'hFFFFF, 6'h24}, 2'd0, 2'd0, 32'h0);
    chk("R10 func ignores opcode", {28'h0, alu_op}, 32'd2);
    apply({6'h0D, 20'hFFFFF, 6'h3F}, 2'd0, 2'd1, 32'h0);
    chk("R10 opcode ignores func", {28'h0, alu_op}, 32'd3);
  endtask

  initial begin
    #2000000;
    bad++;
    total++;
    $display("FAIL watchdog got=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    rst = 1'b0;
    t_idle();
    t_ext();
    t_func();
    t_opc();
    t_unknown();
    t_forced();
    t_zero();
    t_ignore();
    repeat (2) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule